// File: doc/BRIEF.md
# Interlocked Read Handshake Link

This block carries read transfers between a requesting side and a responding side that share no timing strobe. The requester and the responder each run on their own local clock. Each treats the other's handshake line as asynchronous and brings it in through a two-flop synchronizer. A transfer is fully interlocked: every edge of the request-ready line is answered by an edge of the response-ready line, so neither side ever has to guess the other's speed.

The requester side (`hsb_master`) latches an address and a command on a start pulse. It drives them onto the shared lines and lets them settle for `SKEW_CYC` local cycles. Only then does it raise `bus_mrdy`. The responder side (`hsb_slave`) decodes the address when it sees `bus_mrdy` high. It fetches the word from its local data port and presents that word on `bus_data` one cycle before it raises `bus_srdy`. It holds both until it sees `bus_mrdy` fall. The requester captures the word one cycle after the synchronized `bus_srdy` is seen. It then drops `bus_mrdy` together with the address and command, and waits for `bus_srdy` to fall before it accepts a new start. If no response comes within `TIMEOUT_CYC` cycles, the requester flags an error and releases the bus.

Requester states and transitions are as follows:
- M_IDLE goes to M_SETTLE on start when the synchronized response line is low.
- M_SETTLE goes to M_WAIT after `SKEW_CYC` cycles.
- M_WAIT goes to M_CAPTURE on the synchronized response. It goes to M_RELEASE on timeout.
- M_CAPTURE goes to M_RELEASE after one cycle.
- M_RELEASE goes to M_IDLE once the synchronized response line is low.

Responder states and transitions are as follows:
- S_IDLE goes to S_FETCH on request with a hit. It goes to S_SKIP on request with a miss.
- S_FETCH goes to S_PRESENT, and S_PRESENT goes to S_READY.
- S_READY goes to S_IDLE once the synchronized request line is low.
- S_SKIP goes to S_IDLE once the synchronized request line is low.

Top module: `hsb_link`

## Requirements
- R1: While reset is held, `bus_mrdy`, `bus_srdy`, `m_busy`, `m_done` and `m_err` are 0, and `bus_addr` and `bus_data` are 0.
- R2: The address and command are on the bus for at least `SKEW_CYC` (default 2) requester cycles before `bus_mrdy` rises. They stay unchanged while `bus_mrdy` is high.
- R3: The responder answers only when (`bus_addr` & `SLV_MASK`) == `SLV_BASE` (defaults 8'hC0 and 8'h40, so addresses 8'h40..8'h7F) and `bus_cmd` equals the read code 2'b01. For any other address or command it never raises `bus_srdy`.
- R4: The responder drives the fetched word on `bus_data` at least one cycle before `bus_srdy` rises. The word stays unchanged while `bus_srdy` is high.
- R5: After a hit, `m_done` pulses for exactly one requester cycle. At that time `m_rdata` equals the word that `s_fetch_data` returned for that address.
- R6: In the cycle `m_done` is seen, `bus_mrdy` is already low and `bus_addr` is 0, while `bus_srdy` is still high. `bus_srdy` falls only after `bus_mrdy` has fallen.
- R7: `bus_srdy` never rises while `bus_mrdy` is low, and `bus_mrdy` never rises while `bus_srdy` is high.
- R8: If no response arrives, `m_err` pulses exactly 1 + `SKEW_CYC` + `TIMEOUT_CYC` requester cycles after the start pulse is taken (35 with defaults). `m_done` does not pulse, and `bus_mrdy` is low from then on.
- R9: `m_busy` is high from the cycle after a start is taken until the requester returns to idle. A start pulse while busy is ignored: it produces no extra `m_done` or `m_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_m | input | 1 | Requester local clock |
| rst_m_n | input | 1 | Requester active-low reset |
| m_start | input | 1 | Start a read transfer (taken when idle) |
| m_addr | input | ADDR_W | Address for the transfer |
| m_cmd | input | CMD_W | Command for the transfer (2'b01 = read) |
| m_busy | output | 1 | Requester is in a transfer |
| m_done | output | 1 | One-cycle pulse: data captured |
| m_rdata | output | DATA_W | Captured data word |
| m_err | output | 1 | One-cycle pulse: response timeout |
| clk_s | input | 1 | Responder local clock |
| rst_s_n | input | 1 | Responder active-low reset |
| s_fetch_addr | output | ADDR_W | Address the responder looks up locally |
| s_fetch_data | input | DATA_W | Word returned for `s_fetch_addr` |
| bus_addr | output | ADDR_W | Shared address lines (observation) |
| bus_cmd | output | CMD_W | Shared command lines (observation) |
| bus_data | output | DATA_W | Shared data lines (observation) |
| bus_mrdy | output | 1 | Request-ready handshake line |
| bus_srdy | output | 1 | Response-ready handshake line |

## Verification
The assertions assume that `s_fetch_data` settles within one responder cycle of `s_fetch_addr` changing. They also assume that the two resets are released while both handshake lines are low. The bench derives the fetched word combinationally from `s_fetch_addr` and releases both resets together before any start. It issues starts only at requester negative edges. The two clocks run at unrelated periods, so the synchronizers see every phase relation. Random addresses and commands are mixed with directed window edges, command misses, an exact timeout count and a start that arrives during a busy transfer.

// File: rtl/hsb_pkg.sv
package hsb_pkg;
    typedef enum logic [2:0] {
        M_IDLE,
        M_SETTLE,
        M_WAIT,
        M_CAPTURE,
        M_RELEASE
    } mst_state_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SKIP,
        S_FETCH,
        S_PRESENT,
        S_READY
    } slv_state_t;
endpackage

// File: rtl/hsb_sync2.sv
module hsb_sync2 (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q
);
    logic meta_q;
    logic stab_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            stab_q <= 1'b0;
        end else begin
            meta_q <= d_async;
            stab_q <= meta_q;
        end
    end

    assign q = stab_q;
endmodule

// File: rtl/hsb_master.sv
module hsb_master
    import hsb_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int CMD_W       = 2,
    parameter int DATA_W      = 16,
    parameter int SKEW_CYC    = 2,
    parameter int TIMEOUT_CYC = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CMD_W-1:0]  cmd,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic              err,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [CMD_W-1:0]  bus_cmd,
    output logic              bus_mrdy,
    input  logic              bus_srdy_async,
    input  logic [DATA_W-1:0] bus_data
);
    localparam int SK_W = $clog2(SKEW_CYC + 1);
    localparam int TO_W = $clog2(TIMEOUT_CYC + 1);

    mst_state_t        state_q, state_d;
    logic              srdy_s;
    logic [SK_W-1:0]   sk_cnt;
    logic [TO_W-1:0]   to_cnt;
    logic [ADDR_W-1:0] addr_q;
    logic [CMD_W-1:0]  cmd_q;
    logic [DATA_W-1:0] rdata_q;
    logic              done_q, err_q;
    logic              drive;
    logic              expire;

    hsb_sync2 u_srdy_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (bus_srdy_async),
        .q       (srdy_s)
    );

    assign expire = (to_cnt == TO_W'(TIMEOUT_CYC - 1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= M_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            M_IDLE:    if (start && !srdy_s)                  state_d = M_SETTLE;
            M_SETTLE:  if (sk_cnt == SK_W'(SKEW_CYC - 1))      state_d = M_WAIT;
            M_WAIT:    if (srdy_s)                             state_d = M_CAPTURE;
                       else if (expire)                        state_d = M_RELEASE;
            M_CAPTURE:                                         state_d = M_RELEASE;
            M_RELEASE: if (!srdy_s)                            state_d = M_IDLE;
            default:                                           state_d = M_IDLE;
        endcase
    end

    // counters, latched request, captured result
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sk_cnt  <= '0;
            to_cnt  <= '0;
            addr_q  <= '0;
            cmd_q   <= '0;
            rdata_q <= '0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            sk_cnt <= (state_q == M_SETTLE) ? sk_cnt + 1'b1 : '0;
            to_cnt <= (state_q == M_WAIT)   ? to_cnt + 1'b1 : '0;
            if (state_q == M_IDLE && state_d == M_SETTLE) begin
                addr_q <= addr;
                cmd_q  <= cmd;
            end
            if (state_q == M_CAPTURE) rdata_q <= bus_data;
            done_q <= (state_q == M_CAPTURE);
            err_q  <= (state_q == M_WAIT) && !srdy_s && expire;
        end
    end

    // outputs
    always_comb begin
        drive    = (state_q == M_SETTLE) || (state_q == M_WAIT) || (state_q == M_CAPTURE);
        bus_mrdy = (state_q == M_WAIT) || (state_q == M_CAPTURE);
        bus_addr = drive ? addr_q : '0;
        bus_cmd  = drive ? cmd_q  : '0;
        busy     = (state_q != M_IDLE);
        done     = done_q;
        err      = err_q;
        rdata    = rdata_q;
    end

    // checker: cycles the address has been on the bus before request-ready
    logic [SK_W-1:0] pre_cnt;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   pre_cnt <= '0;
        else if (!drive)              pre_cnt <= '0;
        else if (!bus_mrdy && pre_cnt != SK_W'(SKEW_CYC)) pre_cnt <= pre_cnt + 1'b1;
    end

    AST_SETTLE_BEFORE_RDY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_mrdy) |-> pre_cnt == SK_W'(SKEW_CYC)); // R2
    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_mrdy && $past(bus_mrdy)) |-> ($stable(bus_addr) && $stable(bus_cmd))); // R2
    AST_NO_RDY_OVER_SRDY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_mrdy) |-> !srdy_s); // R7
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R5
    AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err)); // R8
    AST_ERR_DROPS_RDY: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !bus_mrdy); // R8
endmodule

// File: rtl/hsb_slave.sv
module hsb_slave
    import hsb_pkg::*;
#(
    parameter int                ADDR_W  = 8,
    parameter int                CMD_W   = 2,
    parameter int                DATA_W  = 16,
    parameter logic [ADDR_W-1:0] BASE    = 8'h40,
    parameter logic [ADDR_W-1:0] MASK    = 8'hC0,
    parameter logic [CMD_W-1:0]  RD_CODE = 2'b01
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CMD_W-1:0]  bus_cmd,
    input  logic              bus_mrdy_async,
    output logic              bus_srdy,
    output logic [DATA_W-1:0] bus_data,
    output logic [ADDR_W-1:0] fetch_addr,
    input  logic [DATA_W-1:0] fetch_data
);
    slv_state_t        state_q, state_d;
    logic              mrdy_s;
    logic              hit;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;

    hsb_sync2 u_mrdy_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (bus_mrdy_async),
        .q       (mrdy_s)
    );

    assign hit = ((bus_addr & MASK) == BASE) && (bus_cmd == RD_CODE);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:    if (mrdy_s) state_d = hit ? S_FETCH : S_SKIP;
            S_SKIP:    if (!mrdy_s) state_d = S_IDLE;
            S_FETCH:   state_d = S_PRESENT;
            S_PRESENT: state_d = S_READY;
            S_READY:   if (!mrdy_s) state_d = S_IDLE;
            default:   state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
        end else begin
            if (state_q == S_IDLE && state_d == S_FETCH) addr_q <= bus_addr;
            if (state_q == S_FETCH) data_q <= fetch_data;
        end
    end

    // outputs
    always_comb begin
        bus_srdy   = (state_q == S_READY);
        bus_data   = (state_q == S_PRESENT || state_q == S_READY) ? data_q : '0;
        fetch_addr = addr_q;
    end

    AST_SRDY_NEEDS_MRDY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_srdy) |-> mrdy_s); // R7
    AST_DATA_LEADS_SRDY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_srdy) |-> $stable(bus_data)); // R4
    AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_srdy && $past(bus_srdy)) |-> $stable(bus_data)); // R4
    AST_SRDY_AFTER_MRDY_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_srdy) |-> !$past(mrdy_s)); // R6
endmodule

// File: rtl/hsb_link.sv
module hsb_link #(
    parameter int                ADDR_W      = 8,
    parameter int                CMD_W       = 2,
    parameter int                DATA_W      = 16,
    parameter int                SKEW_CYC    = 2,
    parameter int                TIMEOUT_CYC = 32,
    parameter logic [ADDR_W-1:0] SLV_BASE    = 8'h40,
    parameter logic [ADDR_W-1:0] SLV_MASK    = 8'hC0,
    parameter logic [CMD_W-1:0]  RD_CODE     = 2'b01
) (
    input  logic              clk_m,
    input  logic              rst_m_n,
    input  logic              m_start,
    input  logic [ADDR_W-1:0] m_addr,
    input  logic [CMD_W-1:0]  m_cmd,
    output logic              m_busy,
    output logic              m_done,
    output logic [DATA_W-1:0] m_rdata,
    output logic              m_err,
    input  logic              clk_s,
    input  logic              rst_s_n,
    output logic [ADDR_W-1:0] s_fetch_addr,
    input  logic [DATA_W-1:0] s_fetch_data,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [CMD_W-1:0]  bus_cmd,
    output logic [DATA_W-1:0] bus_data,
    output logic              bus_mrdy,
    output logic              bus_srdy
);
    hsb_master #(
        .ADDR_W      (ADDR_W),
        .CMD_W       (CMD_W),
        .DATA_W      (DATA_W),
        .SKEW_CYC    (SKEW_CYC),
        .TIMEOUT_CYC (TIMEOUT_CYC)
    ) u_master (
        .clk            (clk_m),
        .rst_n          (rst_m_n),
        .start          (m_start),
        .addr           (m_addr),
        .cmd            (m_cmd),
        .busy           (m_busy),
        .done           (m_done),
        .rdata          (m_rdata),
        .err            (m_err),
        .bus_addr       (bus_addr),
        .bus_cmd        (bus_cmd),
        .bus_mrdy       (bus_mrdy),
        .bus_srdy_async (bus_srdy),
        .bus_data       (bus_data)
    );

    hsb_slave #(
        .ADDR_W  (ADDR_W),
        .CMD_W   (CMD_W),
        .DATA_W  (DATA_W),
        .BASE    (SLV_BASE),
        .MASK    (SLV_MASK),
        .RD_CODE (RD_CODE)
    ) u_slave (
        .clk            (clk_s),
        .rst_n          (rst_s_n),
        .bus_addr       (bus_addr),
        .bus_cmd        (bus_cmd),
        .bus_mrdy_async (bus_mrdy),
        .bus_srdy       (bus_srdy),
        .bus_data       (bus_data),
        .fetch_addr     (s_fetch_addr),
        .fetch_data     (s_fetch_data)
    );
endmodule

// File: tb/sim_hsb_link.sv
`timescale 1ns/1ps
module sim_hsb_link;
    localparam int SKEW    = 2;
    localparam int TMO     = 32;
    localparam int TPER_M  = 20;

    logic        clk_m = 1'b0, clk_s = 1'b0;
    logic        rst_m_n = 1'b0, rst_s_n = 1'b0;
    logic        m_start = 1'b0;
    logic [7:0]  m_addr = '0;
    logic [1:0]  m_cmd = '0;
    logic        m_busy, m_done, m_err;
    logic [15:0] m_rdata;
    logic [7:0]  s_fetch_addr;
    logic [15:0] s_fetch_data;
    logic [7:0]  bus_addr;
    logic [1:0]  bus_cmd;
    logic [15:0] bus_data;
    logic        bus_mrdy, bus_srdy;

    int checks = 0, errors = 0;
    int done_cnt = 0, err_cnt = 0;
    int viol_hs = 0, viol_skew = 0, viol_rel = 0;
    time t_addr = 0;

    always #(TPER_M/2) clk_m = ~clk_m;
    always #7 clk_s = ~clk_s;

    function automatic logic [15:0] word_of(input logic [7:0] a);
        return {a ^ 8'h3C, ~a};
    endfunction

    function automatic bit is_hit(input logic [7:0] a, input logic [1:0] c);
        return ((a & 8'hC0) == 8'h40) && (c == 2'b01);
    endfunction

    assign s_fetch_data = word_of(s_fetch_addr);

    hsb_link u0 (
        .clk_m(clk_m), .rst_m_n(rst_m_n), .m_start(m_start), .m_addr(m_addr),
        .m_cmd(m_cmd), .m_busy(m_busy), .m_done(m_done), .m_rdata(m_rdata),
        .m_err(m_err), .clk_s(clk_s), .rst_s_n(rst_s_n),
        .s_fetch_addr(s_fetch_addr), .s_fetch_data(s_fetch_data),
        .bus_addr(bus_addr), .bus_cmd(bus_cmd), .bus_data(bus_data),
        .bus_mrdy(bus_mrdy), .bus_srdy(bus_srdy)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    // monitors
    always @(posedge clk_m) begin
        if (m_done) done_cnt++;
        if (m_err)  err_cnt++;
    end
    always @(bus_addr) t_addr = $time;
    always @(posedge bus_mrdy) begin
        if (bus_srdy) viol_hs++;                          // R7
        if ($time - t_addr < SKEW * TPER_M) viol_skew++;  // R2
    end
    always @(posedge bus_srdy) if (!bus_mrdy) viol_hs++;  // R7
    always @(negedge bus_srdy) if (bus_mrdy) viol_rel++;  // R6

    task automatic do_read(input logic [7:0] a, input logic [1:0] c, input bit inject);
        int n;
        int d0, e0;
        while (m_busy) @(negedge clk_m);
        d0 = done_cnt; e0 = err_cnt;
        m_start = 1'b1; m_addr = a; m_cmd = c;
        @(negedge clk_m);
        m_start = 1'b0;
        n = 1;
        chk(m_busy == 1'b1, "R9 busy after start", m_busy, 1);
        while (!m_done && !m_err && n < 300) begin
            if (inject && n == 4) begin
                m_start = 1'b1; m_addr = a ^ 8'h01; m_cmd = 2'b01;
            end else m_start = 1'b0;
            @(negedge clk_m);
            n++;
        end
        m_start = 1'b0;
        if (is_hit(a, c)) begin
            chk(m_done == 1'b1, "R5 done pulse", m_done, 1);
            chk(m_rdata == word_of(a), "R5 captured word", m_rdata, word_of(a));
            chk(!bus_mrdy && bus_addr == 8'h00, "R6 request withdrawn", {bus_mrdy, bus_addr}, 0);
            chk(bus_srdy == 1'b1, "R6 response still held", bus_srdy, 1);
        end else begin
            chk(m_err == 1'b1 && m_done == 1'b0, "R3 no answer gives error", {m_err, m_done}, 2'b10);
            chk(n == 1 + SKEW + TMO, "R8 timeout cycle", n, 1 + SKEW + TMO);
            chk(bus_mrdy == 1'b0, "R8 request dropped", bus_mrdy, 0);
        end
        if (inject) begin
            while (m_busy) @(negedge clk_m);
            repeat (60) @(negedge clk_m);
            chk(done_cnt - d0 == 1 && err_cnt == e0, "R9 busy start ignored",
                done_cnt - d0, 1);
            chk(m_busy == 1'b0, "R9 back to idle", m_busy, 0);
        end
    endtask

    initial begin
        #(200000 * TPER_M);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] ra;
        logic [1:0] rc;
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk_m);
        chk(!bus_mrdy && !bus_srdy && !m_busy && !m_done && !m_err, "R1 reset controls",
            {bus_mrdy, bus_srdy, m_busy, m_done, m_err}, 0);
        chk(bus_addr == 0 && bus_data == 0, "R1 reset bus", {bus_addr, bus_data}, 0);
        rst_m_n = 1'b1; rst_s_n = 1'b1;
        repeat (3) @(negedge clk_m);

        do_read(8'h40, 2'b01, 1'b0);   // R3 low window edge
        do_read(8'h7F, 2'b01, 1'b0);   // R3 high window edge
        do_read(8'h3F, 2'b01, 1'b0);   // R3 below window, R8
        do_read(8'h80, 2'b01, 1'b0);   // R3 above window
        do_read(8'h55, 2'b10, 1'b0);   // R3 wrong command
        do_read(8'h66, 2'b01, 1'b1);   // R9 start while busy
        do_read(8'h41, 2'b01, 1'b0);   // R7 back-to-back after release

        for (int i = 0; i < 40; i++) begin
            ra = 8'($urandom);
            if (($urandom % 3) != 0) ra = {2'b01, ra[5:0]};
            rc = (($urandom % 5) == 0) ? 2'($urandom) : 2'b01;
            do_read(ra, rc, 1'b0);
        end

        repeat (20) @(negedge clk_m);
        chk(viol_hs == 0, "R7 interlock order", viol_hs, 0);
        chk(viol_skew == 0, "R2 settle before request", viol_skew, 0);
        chk(viol_rel == 0, "R6 response falls after request", viol_rel, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule